// File: doc/BRIEF.md
# Iterative Fixed-Point Base-2 Exponential Unit

This unit computes two raised to an unsigned fixed-point operand and returns the result as an unsigned 32-bit integer. The operand carries a 5-bit integer part in its top bits and a 27-bit fraction below it. The unit works through the fraction one bit per clock, starting at the least significant bit.

Two normalised 32-bit words drive the loop. The first is a running product that starts at 1.0. The second is a running root that starts at the 2^-27-th power of two. On every step the root is squared to give the next root in the chain. A fixed correction word restores the low bit that truncation loses. When the loop ends, one shift applies the integer part.

A caller pulses `start_i` for one cycle with the operand present. It then waits for the one-cycle `done_o` pulse and reads `result_o`, which holds its value until the next accepted start.

Top module: `exp2_iter_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `busy_o` and `done_o` are 0 and `result_o` is 0. Reset is synchronous and active high. Asserting it during a computation abandons that computation.
- R2: A `start_i` pulse seen while `busy_o` is 0 makes `busy_o` 1 from the next cycle. `done_o` is high for exactly one cycle, and `busy_o` is 0 in that same cycle.
- R3: `done_o` rises 29 clock edges after the edge that samples the accepted start. That is one setup cycle, 27 step cycles and one shift cycle.
- R4: A `start_i` pulse while `busy_o` is 1 is ignored. The running job completes with its own operand and its own latency, and no second `done_o` follows.
- R5: With a zero fraction (operand bits [26:0] = 0) and integer part k = operand bits [31:27], the result is exactly 2^k, for k from 0 to 31.
- R6: The product P starts at 0x8000_0000, the root Q at 0x8000_000B and the correction word C at 0x173C_E500. There is one step for each fraction bit j = 0..26. On step j:
  - when operand bit j is 1, P becomes (upper 32 bits of P*Q) shifted left by 1;
  - in every step, Q becomes (upper 32 bits of Q*Q) shifted left by 1, with its bit 0 set to C bit (31-j).
- R7: The result is P shifted logically right by 31-k, so for k = 31 the result equals P. Two operands with the same fraction and integer parts k and 31 give results that differ by exactly a right shift of 31-k.
- R8: While `busy_o` is 0, `result_o` does not change, even when `operand_i` changes without a start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin; accepted only when idle |
| operand_i | input | 32 | Unsigned operand: integer [31:27], fraction [26:0] |
| busy_o | output | 1 | High from the cycle after an accepted start until the result is valid |
| done_o | output | 1 | One-cycle pulse marking a new valid result |
| result_o | output | 32 | Unsigned integer 2^operand, held until the next accepted start |

## Verification
The assertions assume that a start arriving while busy must leave the computation untouched. They also assume the running product keeps its top bit set throughout a job, which holds only because both multiplied words are normalised and the total fraction stays below one. The stimulus keeps every start pulse one cycle wide and releases reset only between jobs or as a deliberate abort. It deliberately raises start mid-job with a different operand, to exercise the ignore path inside those assumptions. Results for fractional operands are matched against a bench model that restates the step rules with 64-bit arithmetic.

// File: rtl/exp2_iter_pkg.sv
package exp2_iter_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RUN   = 2'd2,
    ST_SHIFT = 2'd3
  } exp2_state_e;
endpackage

// File: rtl/exp2_iter_ctrl.sv
module exp2_iter_ctrl
  import exp2_iter_pkg::*;
#(
  parameter int FRAC_BITS = 27,
  localparam int CNT_W = (FRAC_BITS > 1) ? $clog2(FRAC_BITS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic load_ev,
  output logic init_ev,
  output logic step_ev,
  output logic fin_ev,
  output logic busy_o,
  output logic done_o
);
  exp2_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic last_ev;

  assign busy_o  = (state_q != ST_IDLE);
  assign load_ev = (state_q == ST_IDLE) && start_i;
  assign init_ev = (state_q == ST_SETUP);
  assign step_ev = (state_q == ST_RUN);
  assign last_ev = step_ev && (cnt_q == '0);
  assign fin_ev  = (state_q == ST_SHIFT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_SETUP;
      ST_SETUP: state_d = ST_RUN;
      ST_RUN:   if (last_ev) state_d = ST_SHIFT;
      ST_SHIFT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= fin_ev;
      if (init_ev)      cnt_q <= CNT_W'(FRAC_BITS - 1);
      else if (step_ev) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/exp2_iter_datapath.sv
module exp2_iter_datapath #(
  parameter int W         = 32,
  parameter int FRAC_BITS = 27,
  parameter logic [W-1:0] SEED_PROD = 32'h8000_0000,
  parameter logic [W-1:0] SEED_ROOT = 32'h8000_000B,
  parameter logic [W-1:0] CORR_WORD = 32'h173C_E500,
  localparam int INT_BITS = W - FRAC_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_ev,
  input  logic                init_ev,
  input  logic                step_ev,
  input  logic [W-1:0]        operand_i,
  output logic [W-1:0]        prod_o,
  output logic [INT_BITS-1:0] ipart_o
);
  logic [W-1:0]         opnd_q;
  logic [W-1:0]         root_q;
  logic [W-1:0]         corr_q;
  logic [FRAC_BITS-1:0] fbits_q;
  logic                 take_bit;

  // upper half of the double-width product, renormalised by one place
  function automatic logic [W-1:0] mul_renorm(input logic [W-1:0] a,
                                              input logic [W-1:0] b);
    logic [2*W-1:0] full;
    full = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    return {full[2*W-2:W], 1'b0};
  endfunction

  assign take_bit = fbits_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      opnd_q  <= '0;
      prod_o  <= SEED_PROD;
      root_q  <= SEED_ROOT;
      corr_q  <= CORR_WORD;
      fbits_q <= '0;
      ipart_o <= '0;
    end else begin
      if (load_ev) opnd_q <= operand_i;
      if (init_ev) begin
        prod_o  <= SEED_PROD;
        root_q  <= SEED_ROOT;
        corr_q  <= CORR_WORD;
        fbits_q <= opnd_q[FRAC_BITS-1:0];
        ipart_o <= opnd_q[W-1:FRAC_BITS];
      end else if (step_ev) begin
        if (take_bit) prod_o <= mul_renorm(prod_o, root_q);
        root_q  <= mul_renorm(root_q, root_q) | {{(W-1){1'b0}}, corr_q[W-1]};
        corr_q  <= corr_q << 1;
        fbits_q <= fbits_q >> 1;
      end
    end
  end
endmodule

// File: rtl/exp2_iter_outstage.sv
module exp2_iter_outstage #(
  parameter int W         = 32,
  parameter int FRAC_BITS = 27,
  localparam int INT_BITS = W - FRAC_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fin_ev,
  input  logic [W-1:0]        prod_i,
  input  logic [INT_BITS-1:0] ipart_i,
  output logic [W-1:0]        result_o
);
  // signed shift by (ipart - (W-1)); negative moves right
  function automatic logic [W-1:0] final_scale(input logic [W-1:0] p,
                                               input logic [INT_BITS-1:0] k);
    int amt;
    amt = int'(k) - (W - 1);
    if (amt >= 0) return p << amt;
    else          return p >> (-amt);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)         result_o <= '0;
    else if (fin_ev) result_o <= final_scale(prod_i, ipart_i);
  end
endmodule

// File: rtl/exp2_iter_unit.sv
module exp2_iter_unit #(
  parameter int W         = 32,
  parameter int FRAC_BITS = 27,
  parameter logic [W-1:0] SEED_PROD = 32'h8000_0000,
  parameter logic [W-1:0] SEED_ROOT = 32'h8000_000B,
  parameter logic [W-1:0] CORR_WORD = 32'h173C_E500
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] operand_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  localparam int INT_BITS = W - FRAC_BITS;

  logic                load_ev;
  logic                init_ev;
  logic                step_ev;
  logic                fin_ev;
  logic [W-1:0]        prod_w;
  logic [INT_BITS-1:0] ipart_w;

  exp2_iter_ctrl #(.FRAC_BITS(FRAC_BITS)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .load_ev (load_ev),
    .init_ev (init_ev),
    .step_ev (step_ev),
    .fin_ev  (fin_ev),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  exp2_iter_datapath #(
    .W(W), .FRAC_BITS(FRAC_BITS),
    .SEED_PROD(SEED_PROD), .SEED_ROOT(SEED_ROOT), .CORR_WORD(CORR_WORD)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .load_ev   (load_ev),
    .init_ev   (init_ev),
    .step_ev   (step_ev),
    .operand_i (operand_i),
    .prod_o    (prod_w),
    .ipart_o   (ipart_w)
  );

  exp2_iter_outstage #(.W(W), .FRAC_BITS(FRAC_BITS)) u_out (
    .clk      (clk),
    .rst      (rst),
    .fin_ev   (fin_ev),
    .prod_i   (prod_w),
    .ipart_i  (ipart_w),
    .result_o (result_o)
  );
endmodule

// File: rtl/exp2_iter_unit_chk.sv
module exp2_iter_unit_chk #(
  parameter int W         = 32,
  parameter int FRAC_BITS = 27
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] result_o,
  input logic         fin_ev,
  input logic [W-1:0] prod_w
);
  localparam int LAT_W = $clog2(FRAC_BITS + 4) + 1;
  logic [LAT_W-1:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy_o) lat_cnt <= '0;
    else                lat_cnt <= lat_cnt + 1'b1;
  end

  p_busy_after_start_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o ##1 !done_o));

  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    fin_ev |-> (lat_cnt == LAT_W'(FRAC_BITS + 1)));

  p_busy_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !fin_ev) |=> busy_o);

  p_prod_norm_r6: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> prod_w[W-1]);

  p_result_stable_r8: assert property (@(posedge clk) disable iff (rst)
    !busy_o |=> $stable(result_o));
endmodule

bind exp2_iter_unit exp2_iter_unit_chk #(.W(W), .FRAC_BITS(FRAC_BITS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o),
  .fin_ev   (fin_ev),
  .prod_w   (prod_w)
);

// File: tb/exp2_iter_unit_bench.sv
module exp2_iter_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] operand_i = '0;
  logic        busy_o, done_o;
  logic [31:0] result_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  exp2_iter_unit u_exp2_iter_unit (
    .clk(clk), .rst(rst), .start_i(start_i), .operand_i(operand_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  // zero-fraction and easily bounded operands: {operand, expected}
  localparam logic [63:0] VEC [0:7] = '{
    {32'h0000_0000, 32'h0000_0001},
    {32'h0800_0000, 32'h0000_0002},
    {32'h5000_0000, 32'h0000_0400},
    {32'h7800_0000, 32'h0000_8000},
    {32'hF800_0000, 32'h8000_0000},
    {32'h07FF_FFFF, 32'h0000_0001},
    {32'h0FFF_FFFF, 32'h0000_0003},
    {32'h1400_0000, 32'h0000_0005}
  };

  localparam logic [31:0] FRAC_OPS [0:6] = '{
    32'h0C00_0000, 32'hFC00_0000, 32'h0000_0001, 32'hF800_0001,
    32'h3ABC_DEF1, 32'hFFFF_FFFF, 32'h8AAA_AAAA
  };

  // independent restatement of the step rules with 64-bit words
  function automatic logic [31:0] model(input logic [31:0] x);
    longint unsigned p, q, t;
    logic [31:0] c;
    int k;
    p = 64'h8000_0000;
    q = 64'h8000_000B;
    c = 32'h173C_E500;
    for (int j = 0; j < 27; j++) begin
      if (x[j]) begin
        t = p * q;
        p = (t >> 31) & 64'hFFFF_FFFE;
      end
      t = q * q;
      q = ((t >> 31) & 64'hFFFF_FFFE) | longint'(c[31 - j]);
    end
    k = int'(x[31:27]);
    return 32'(p >> (31 - k));
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // drive one job, return result and edge count from start to done
  task automatic run_op(input logic [31:0] op, output logic [31:0] res,
                        output int lat);
    @(negedge clk);
    operand_i = op;
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R2 busy after start", 32'(busy_o), 32'd1);
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!done_o && lat < 100);
    res = result_o;
    check(busy_o == 1'b0, "R2 busy low with done", 32'(busy_o), 32'd0);
    @(negedge clk);
    check(done_o == 1'b0, "R2 done one cycle", 32'(done_o), 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, r2;
    int lat;
    int extra;

    // R1 reset state
    repeat (3) @(negedge clk);
    check(busy_o == 0 && done_o == 0 && result_o == 0, "R1 in reset",
          result_o, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(busy_o == 0 && done_o == 0 && result_o == 0, "R1 after release",
          {30'd0, busy_o, done_o}, 32'd0);

    // R5 and bounded vectors, R3 latency
    for (int i = 0; i < 8; i++) begin
      run_op(VEC[i][63:32], r, lat);
      check(r == VEC[i][31:0], "R5 table result", r, VEC[i][31:0]);
      check(lat == 29, "R3 latency", 32'(lat), 32'd29);
    end

    // R6 fractional operands against the model
    for (int i = 0; i < 7; i++) begin
      run_op(FRAC_OPS[i], r, lat);
      check(r == model(FRAC_OPS[i]), "R6 fractional result", r, model(FRAC_OPS[i]));
    end

    // R7 integer part scales by a plain right shift
    run_op(32'hFC00_0000, r, lat);
    run_op(32'h0400_0000, r2, lat);
    check(r2 == (r >> 31), "R7 k=0 vs k=31", r2, r >> 31);
    run_op(32'hF923_4567, r, lat);
    run_op(32'h6923_4567, r2, lat);
    check(r2 == (r >> 18), "R7 k=13 vs k=31", r2, r >> 18);

    // R8 result held while idle, operand wiggling
    r = result_o;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      operand_i = 32'hDEAD_0000 + 32'(i);
    end
    @(negedge clk);
    check(result_o == r, "R8 result stable idle", result_o, r);

    // R4 start while busy is ignored
    @(negedge clk);
    operand_i = 32'h2345_6789;
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    operand_i = 32'hF000_0000;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 6;
    while (!done_o && lat < 100) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    check(result_o == model(32'h2345_6789), "R4 first operand kept",
          result_o, model(32'h2345_6789));
    check(lat == 29, "R4 latency unchanged", 32'(lat), 32'd29);
    extra = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done_o) extra++;
    end
    check(extra == 0, "R4 no second done", 32'(extra), 32'd0);

    // R1 reset mid-job abandons it
    @(negedge clk);
    operand_i = 32'h5555_5555;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (8) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(busy_o == 0 && done_o == 0 && result_o == 0, "R1 mid-job reset",
          result_o, 32'd0);
    extra = 0;
    for (int i = 0; i < 35; i++) begin
      @(negedge clk);
      if (done_o || busy_o) extra++;
    end
    check(extra == 0, "R1 abandoned job silent", 32'(extra), 32'd0);

    // R2 service resumes after abort
    run_op(32'h1000_0000, r, lat);
    check(r == 32'd4, "R2 job after abort", r, 32'd4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule